// File: doc/BRIEF.md
# Gene-Configured Logic Cell Grid with Truth-Table Scorer

This block is a rectangular grid of small logic cells whose wiring and cell functions all come from a loaded genome. Each cell has three input selectors and a five-bit function code. The selectors name pins. Pins 0 to N_IN-1 are the primary inputs, and cell k (k = column*ROWS + row) drives pin N_IN+k. The cell function is taken from a fixed set of twenty codes. Sixteen of them are two-input functions and four are selectors steered by the third input. A set of output genes decides which pin drives each primary output. The whole grid is combinational from inputs to outputs, and the genome is written one gene per clock through an indexed load port.

A cell may only read primary inputs or cells lying within LBACK columns before its own. It may never read its own column or any later column. Any gene that breaks this rule, names an unknown function code or names a pin that does not exist raises a flag. The offending value reads as 0.

A scoring controller sits around the grid. On a start pulse it drives every one of the 2^N_IN input patterns into the grid, one pattern per clock. A target output row is supplied from outside for the pattern currently shown. For each pattern the controller adds the number of output bits that agree with that row to a score. A gene write aborts a run in progress.

Top module: `lga_top`

## Requirements
- R1: A write with gene_we high and gene_idx below ROWS*COLS+N_OUT stores gene_data at that index on the clock edge. Indices 0..ROWS*COLS-1 are cell genes, numbered column*ROWS+row. Index ROWS*COLS+j is the output gene for output j. Within a gene, the first selector sits in bits [SW-1:0], the second in [2SW-1:SW], the third in [3SW-1:2SW] and the function code in [3SW+4:3SW], where SW = clog2(N_IN+ROWS*COLS). An output gene uses only its first selector. A write with a larger index changes nothing.
- R2: Primary output j equals the value of the pin named by output gene j. Pins 0..N_IN-1 are the primary inputs, and pin N_IN+k is the output of cell k.
- R3: With first input a and second input b, the codes work as follows. Code 0 gives 0 and code 1 gives 1. Codes 2 and 3 pass a and b. Codes 4 and 5 give NOT a and NOT b. Codes 6, 7, 8 and 9 give a&b, a&~b, ~a&b and ~a&~b. Code 10 gives a^b and code 11 gives a^~b. Codes 12, 13, 14 and 15 give a|b, a|~b, ~a|b and ~a|~b. The third input never changes the result of these codes.
- R4: Codes 16 to 19 are selected by the third input c. When c=0 the output is a for codes 16 and 17, and NOT a for codes 18 and 19. When c=1 the output is b for codes 16 and 18, and NOT b for codes 17 and 19.
- R5: Take a cell in column col. A selector is legal when it names a primary input, or a cell whose column lies in [col-LBACK, col-1]. All three selectors are checked, including the unused third one. An illegal selector reads 0 and raises illegal.
- R6: A function code above 19 makes the cell output 0 and raises illegal.
- R7: An output gene naming a pin at or above N_IN+ROWS*COLS makes that output 0 and raises illegal. illegal is low whenever every gene is legal.
- R8: When no run is active, the grid is fed from prim_in.
- R9: The controller has three states: IDLE, SWEEP and DONE. In IDLE or DONE, a start pulse moves it to SWEEP with the pattern at 0. In SWEEP, the pattern advances by one each clock, and the step from pattern 2^N_IN-1 moves it to DONE. busy is high in SWEEP and done is high in DONE. A start pulse during SWEEP is ignored.
- R10: Each SWEEP clock adds to score the number of output bits that equal tgt_row for the pattern shown on pat_idx. A start pulse clears score first.
- R11: A gene write in any state returns the controller to IDLE and clears score and the pattern.
- R12: After reset every gene is 0. That means each cell computes constant 0 and each output follows pin 0. The controller is in IDLE with score 0, and illegal is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gene_we | input | 1 | Gene write strobe |
| gene_idx | input | IW | Gene index to write |
| gene_data | input | GW | Gene contents (three selectors and a function code) |
| prim_in | input | N_IN | Grid inputs when no run is active |
| start | input | 1 | Begin a scoring run |
| tgt_row | input | N_OUT | Target outputs for the pattern on pat_idx |
| prim_out | output | N_OUT | Grid outputs |
| illegal | output | 1 | Some gene holds an illegal selector or function code |
| pat_idx | output | N_IN | Pattern driven into the grid during a run |
| busy | output | 1 | Controller in SWEEP |
| done | output | 1 | Controller in DONE |
| score | output | SCW | Count of matching output bits |

## Verification
The bench builds the default grid: four inputs, two outputs, a four-by-four array and a two-column look-back window. With these values every input pattern fits in one sixteen-clock run. Column 3 can reach column 1 but not column 0, so the window edge is reachable from both sides. Own-column and later-column reads, out-of-range output pins and codes 20 and above can all be driven by hand. A hand-wired full adder is scored against its own truth table and against a table with the sum inverted, and a run is aborted midway by a gene write.

// File: rtl/lga_pkg.sv
package lga_pkg;

    localparam int FUNC_W    = 5;
    localparam int FUNC_LAST = 19;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SWEEP = 2'd1,
        ST_DONE  = 2'd2
    } sweep_state_e;

    // Cell function set: codes 0..15 use only a and b, 16..19 select on c
    function automatic logic cell_fn(input logic [FUNC_W-1:0] f,
                                     input logic a, input logic b, input logic c);
        logic y;
        case (f)
            5'd0:  y = 1'b0;
            5'd1:  y = 1'b1;
            5'd2:  y = a;
            5'd3:  y = b;
            5'd4:  y = ~a;
            5'd5:  y = ~b;
            5'd6:  y = a & b;
            5'd7:  y = a & ~b;
            5'd8:  y = ~a & b;
            5'd9:  y = ~a & ~b;
            5'd10: y = a ^ b;
            5'd11: y = a ^ ~b;
            5'd12: y = a | b;
            5'd13: y = a | ~b;
            5'd14: y = ~a | b;
            5'd15: y = ~a | ~b;
            5'd16: y = c ? b  : a;
            5'd17: y = c ? ~b : a;
            5'd18: y = c ? b  : ~a;
            5'd19: y = c ? ~b : ~a;
            default: y = 1'b0;
        endcase
        return y;
    endfunction

endpackage

// File: rtl/lga_pick.sv
module lga_pick #(
    parameter int W  = 4,
    parameter int SW = 5
) (
    input  logic [W-1:0]  vec,
    input  logic [SW-1:0] sel,
    input  logic          ok,
    output logic          bit_o
);
    always_comb begin
        bit_o = 1'b0;
        if (ok) begin
            for (int i = 0; i < W; i++) begin
                if (sel == SW'(i)) bit_o = vec[i];
            end
        end
    end
endmodule

// File: rtl/lga_cell.sv
module lga_cell
    import lga_pkg::*;
(
    input  logic              in_a,
    input  logic              in_b,
    input  logic              in_c,
    input  logic [FUNC_W-1:0] fcode,
    output logic              y,
    output logic              bad_code
);
    always_comb begin
        bad_code = (fcode > FUNC_W'(FUNC_LAST));
        y        = bad_code ? 1'b0 : cell_fn(fcode, in_a, in_b, in_c);
    end
endmodule

// File: rtl/lga_gene_store.sv
module lga_gene_store
    import lga_pkg::*;
#(
    parameter int N_IN  = 4,
    parameter int N_OUT = 2,
    parameter int ROWS  = 4,
    parameter int COLS  = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic gene_we,
    input  logic [$clog2(ROWS*COLS+N_OUT)-1:0] gene_idx,
    input  logic [3*$clog2(N_IN+ROWS*COLS)+FUNC_W-1:0] gene_data,
    output logic [3*$clog2(N_IN+ROWS*COLS)+FUNC_W-1:0] cell_gene [ROWS*COLS],
    output logic [$clog2(N_IN+ROWS*COLS)-1:0] out_src [N_OUT]
);
    localparam int NCELL = ROWS * COLS;
    localparam int NPIN  = N_IN + NCELL;
    localparam int SW    = $clog2(NPIN);
    localparam int GW    = 3 * SW + FUNC_W;
    localparam int NGENE = NCELL + N_OUT;
    localparam int IW    = $clog2(NGENE);
    localparam logic [IW-1:0] IDX_MAX = IW'(NGENE - 1);

    logic [GW-1:0] mem [NGENE];
    logic          wr_ok;

    assign wr_ok = gene_we && (gene_idx <= IDX_MAX);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NGENE; i++) mem[i] <= '0;
        end else if (wr_ok) begin
            mem[gene_idx] <= gene_data;
        end
    end

    for (genvar k = 0; k < NCELL; k++) begin : g_cell
        assign cell_gene[k] = mem[k];
    end
    for (genvar j = 0; j < N_OUT; j++) begin : g_out
        logic [GW-1:0] og;
        assign og         = mem[NCELL + j];
        assign out_src[j] = og[SW-1:0];
    end

    // R1: a legal write lands in the addressed slot
    assert_gene_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ok |=> (mem[$past(gene_idx)] == $past(gene_data)));

endmodule

// File: rtl/lga_array.sv
module lga_array
    import lga_pkg::*;
#(
    parameter int N_IN  = 4,
    parameter int N_OUT = 2,
    parameter int ROWS  = 4,
    parameter int COLS  = 4,
    parameter int LBACK = 2
) (
    input  logic [N_IN-1:0] prim,
    input  logic [3*$clog2(N_IN+ROWS*COLS)+FUNC_W-1:0] cell_gene [ROWS*COLS],
    input  logic [$clog2(N_IN+ROWS*COLS)-1:0] out_src [N_OUT],
    output logic [N_OUT-1:0] prim_out,
    output logic             illegal
);
    localparam int NCELL = ROWS * COLS;
    localparam int NPIN  = N_IN + NCELL;
    localparam int SW    = $clog2(NPIN);
    localparam logic [SW-1:0] NIN_L   = SW'(N_IN);
    localparam logic [SW-1:0] PIN_MAX = SW'(NPIN - 1);

    logic [ROWS-1:0]  colv [COLS];
    logic [NCELL-1:0] cell_bad;
    logic [N_OUT-1:0] out_bad;
    logic [NPIN-1:0]  allp;

    assign allp[N_IN-1:0] = prim;

    for (genvar c = 0; c < COLS; c++) begin : g_col
        localparam int AW    = N_IN + c * ROWS;
        localparam int LOCOL = (c > LBACK) ? (c - LBACK) : 0;
        localparam logic [SW-1:0] AW_L = SW'(AW);
        localparam logic [SW-1:0] LO_L = SW'(N_IN + LOCOL * ROWS);

        logic [AW-1:0] avail;
        assign avail[N_IN-1:0] = prim;
        for (genvar j = 0; j < c; j++) begin : g_prev
            assign avail[N_IN + j*ROWS +: ROWS] = colv[j];
        end
        assign allp[N_IN + c*ROWS +: ROWS] = colv[c];

        for (genvar r = 0; r < ROWS; r++) begin : g_row
            localparam int K = c * ROWS + r;
            logic [SW-1:0]     sa, sb, sc;
            logic [FUNC_W-1:0] fc;
            logic              ok_a, ok_b, ok_c;
            logic              va, vb, vc;
            logic              y, bad_fc;

            assign sa = cell_gene[K][SW-1:0];
            assign sb = cell_gene[K][2*SW-1:SW];
            assign sc = cell_gene[K][3*SW-1:2*SW];
            assign fc = cell_gene[K][3*SW +: FUNC_W];

            assign ok_a = (sa < NIN_L) || ((sa >= LO_L) && (sa < AW_L));
            assign ok_b = (sb < NIN_L) || ((sb >= LO_L) && (sb < AW_L));
            assign ok_c = (sc < NIN_L) || ((sc >= LO_L) && (sc < AW_L));

            lga_pick #(.W(AW), .SW(SW)) u_pa (.vec(avail), .sel(sa), .ok(ok_a), .bit_o(va));
            lga_pick #(.W(AW), .SW(SW)) u_pb (.vec(avail), .sel(sb), .ok(ok_b), .bit_o(vb));
            lga_pick #(.W(AW), .SW(SW)) u_pc (.vec(avail), .sel(sc), .ok(ok_c), .bit_o(vc));

            lga_cell u_cell (
                .in_a(va), .in_b(vb), .in_c(vc),
                .fcode(fc), .y(y), .bad_code(bad_fc)
            );

            assign colv[c][r]  = y;
            assign cell_bad[K] = bad_fc | ~ok_a | ~ok_b | ~ok_c;
        end
    end

    for (genvar j = 0; j < N_OUT; j++) begin : g_outsel
        logic ok;
        assign ok         = (out_src[j] <= PIN_MAX);
        assign out_bad[j] = ~ok;
        lga_pick #(.W(NPIN), .SW(SW)) u_po (
            .vec(allp), .sel(out_src[j]), .ok(ok), .bit_o(prim_out[j])
        );
    end

    assign illegal = (|cell_bad) | (|out_bad);

endmodule

// File: rtl/lga_sweep.sv
module lga_sweep
    import lga_pkg::*;
#(
    parameter int N_IN  = 4,
    parameter int N_OUT = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic gene_we,
    input  logic start,
    input  logic [N_OUT-1:0] row_out,
    input  logic [N_OUT-1:0] tgt_row,
    output logic [N_IN-1:0]  pattern,
    output logic             busy,
    output logic             done,
    output logic [$clog2(N_OUT*(2**N_IN)+1)-1:0] score
);
    localparam int NPAT = 2 ** N_IN;
    localparam int SCW  = $clog2(N_OUT * NPAT + 1);
    localparam logic [N_IN-1:0] LAST = '1;
    localparam logic [SCW-1:0]  SMAX = SCW'(N_OUT * NPAT);

    sweep_state_e   state_q, state_d;
    logic [SCW-1:0] hits;

    always_comb begin
        hits = '0;
        for (int j = 0; j < N_OUT; j++) begin
            hits = hits + {{(SCW-1){1'b0}}, (row_out[j] == tgt_row[j])};
        end
    end

    // next-state selection
    always_comb begin
        state_d = state_q;
        if (gene_we) begin
            state_d = ST_IDLE;                       // abort / reload
        end else begin
            unique case (state_q)
                ST_IDLE:  if (start) state_d = ST_SWEEP;            // go
                ST_SWEEP: if (pattern == LAST) state_d = ST_DONE;   // finish
                ST_DONE:  if (start) state_d = ST_SWEEP;            // rerun
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pattern <= '0;
            score   <= '0;
        end else if (gene_we) begin
            pattern <= '0;
            score   <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE, ST_DONE: begin
                    if (start) begin
                        pattern <= '0;
                        score   <= '0;
                    end
                end
                ST_SWEEP: begin
                    score   <= score + hits;
                    pattern <= pattern + 1'b1;
                end
                default: begin
                    pattern <= '0;
                    score   <= '0;
                end
            endcase
        end
    end

    always_comb begin
        busy = (state_q == ST_SWEEP);
        done = (state_q == ST_DONE);
    end

    assert_abort_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
        gene_we |=> (score == '0 && !busy && !done && pattern == '0));

    assert_pattern_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !gene_we && pattern != LAST) |=> (busy && pattern == $past(pattern) + 1'b1));

    assert_finish_after_last_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !gene_we && pattern == LAST) |=> (done && !busy));

    assert_score_ceiling_R10: assert property (@(posedge clk) disable iff (!rst_n)
        score <= SMAX);

    assert_score_monotone_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !gene_we) |=> (score >= $past(score)));

endmodule

// File: rtl/lga_top.sv
module lga_top
    import lga_pkg::*;
#(
    parameter int N_IN  = 4,
    parameter int N_OUT = 2,
    parameter int ROWS  = 4,
    parameter int COLS  = 4,
    parameter int LBACK = 2,
    localparam int NCELL = ROWS * COLS,
    localparam int SW    = $clog2(N_IN + NCELL),
    localparam int GW    = 3 * SW + FUNC_W,
    localparam int IW    = $clog2(NCELL + N_OUT),
    localparam int SCW   = $clog2(N_OUT * (2 ** N_IN) + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             gene_we,
    input  logic [IW-1:0]    gene_idx,
    input  logic [GW-1:0]    gene_data,
    input  logic [N_IN-1:0]  prim_in,
    input  logic             start,
    input  logic [N_OUT-1:0] tgt_row,
    output logic [N_OUT-1:0] prim_out,
    output logic             illegal,
    output logic [N_IN-1:0]  pat_idx,
    output logic             busy,
    output logic             done,
    output logic [SCW-1:0]   score
);
    logic [GW-1:0]   cell_gene [NCELL];
    logic [SW-1:0]   out_src   [N_OUT];
    logic [N_IN-1:0] grid_in;

    lga_gene_store #(.N_IN(N_IN), .N_OUT(N_OUT), .ROWS(ROWS), .COLS(COLS)) u_store (
        .clk(clk), .rst_n(rst_n), .gene_we(gene_we), .gene_idx(gene_idx),
        .gene_data(gene_data), .cell_gene(cell_gene), .out_src(out_src)
    );

    assign grid_in = busy ? pat_idx : prim_in;

    lga_array #(.N_IN(N_IN), .N_OUT(N_OUT), .ROWS(ROWS), .COLS(COLS), .LBACK(LBACK)) u_array (
        .prim(grid_in), .cell_gene(cell_gene), .out_src(out_src),
        .prim_out(prim_out), .illegal(illegal)
    );

    lga_sweep #(.N_IN(N_IN), .N_OUT(N_OUT)) u_sweep (
        .clk(clk), .rst_n(rst_n), .gene_we(gene_we), .start(start),
        .row_out(prim_out), .tgt_row(tgt_row), .pattern(pat_idx),
        .busy(busy), .done(done), .score(score)
    );

endmodule

// File: tb/lga_top_tb.sv
`timescale 1ns/1ps
module lga_top_tb;
    localparam int N_IN = 4, N_OUT = 2, ROWS = 4, COLS = 4, LB = 2;
    localparam int NC = ROWS * COLS, NP = N_IN + NC, SW = 5, GW = 3 * SW + 5;
    localparam int NG = NC + N_OUT, IW = 5, SCW = 6, NPAT = 16;

    logic clk = 0, rst_n = 0, gene_we = 0, start = 0;
    logic [IW-1:0]    gene_idx = '0;
    logic [GW-1:0]    gene_data = '0;
    logic [N_IN-1:0]  prim_in = '0;
    logic [N_OUT-1:0] tgt_row, prim_out;
    logic             illegal, busy, done;
    logic [N_IN-1:0]  pat_idx;
    logic [SCW-1:0]   score;
    int tsel = 0;
    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    lga_top u_dut (
        .clk(clk), .rst_n(rst_n), .gene_we(gene_we), .gene_idx(gene_idx),
        .gene_data(gene_data), .prim_in(prim_in), .start(start), .tgt_row(tgt_row),
        .prim_out(prim_out), .illegal(illegal), .pat_idx(pat_idx), .busy(busy),
        .done(done), .score(score)
    );

    // reference formulas written from the requirement text
    function automatic int fref(int code, int a, int b, int c);
        if (code == 0) return 0;
        if (code == 1) return 1;
        if (code == 2) return a;
        if (code == 3) return b;
        if (code == 4) return 1 - a;
        if (code == 5) return 1 - b;
        if (code >= 6 && code <= 9)
            return (a ^ ((code - 6) >> 1)) & (b ^ ((code - 6) & 1));
        if (code == 10) return a ^ b;
        if (code == 11) return a ^ b ^ 1;
        if (code >= 12 && code <= 15)
            return (a ^ ((code - 12) >> 1)) | (b ^ ((code - 12) & 1));
        if (code >= 16 && code <= 19)
            return (c == 0) ? (a ^ ((code - 16) >> 1)) : (b ^ ((code - 16) & 1));
        return 0;
    endfunction

    function automatic logic [1:0] tgt_fn(int p, int sel);
        int a, b, c, s, cy;
        a = p & 1; b = (p >> 1) & 1; c = (p >> 2) & 1;
        s = a ^ b ^ c; cy = (a & b) | (a & c) | (b & c);
        if (sel != 0) s = s ^ 1;
        return 2'(cy * 2 + s);
    endfunction

    assign tgt_row = tgt_fn(int'(pat_idx), tsel);

    // behavioural model state
    int ma[NC], mb[NC], mc[NC], mf[NC], mo[N_OUT];
    int mst = 0, mpat = 0, mscore = 0;

    function automatic void model_eval(input int pv, output int outv, output int bad);
        int pin[NP];
        int s[3];
        int v[3];
        int col;
        bad = 0;
        for (int i = 0; i < NP; i++) pin[i] = 0;
        for (int i = 0; i < N_IN; i++) pin[i] = (pv >> i) & 1;
        for (int k = 0; k < NC; k++) begin
            col = k / ROWS;
            s[0] = ma[k]; s[1] = mb[k]; s[2] = mc[k];
            for (int t = 0; t < 3; t++) begin
                if (s[t] < N_IN) v[t] = pin[s[t]];
                else if (s[t] < NP && (s[t] - N_IN) / ROWS < col
                         && (s[t] - N_IN) / ROWS >= col - LB) v[t] = pin[s[t]];
                else begin v[t] = 0; bad = 1; end
            end
            if (mf[k] > 19) bad = 1;
            pin[N_IN + k] = fref(mf[k], v[0], v[1], v[2]);
        end
        outv = 0;
        for (int j = 0; j < N_OUT; j++) begin
            if (mo[j] < NP) outv = outv | (pin[mo[j]] << j);
            else bad = 1;
        end
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < NC; k++) begin ma[k] = 0; mb[k] = 0; mc[k] = 0; mf[k] = 0; end
            for (int j = 0; j < N_OUT; j++) mo[j] = 0;
            mst = 0; mpat = 0; mscore = 0;
        end else if (gene_we && int'(gene_idx) < NG) begin
            if (int'(gene_idx) < NC) begin
                ma[gene_idx] = int'(gene_data[SW-1:0]);
                mb[gene_idx] = int'(gene_data[2*SW-1:SW]);
                mc[gene_idx] = int'(gene_data[3*SW-1:2*SW]);
                mf[gene_idx] = int'(gene_data[3*SW +: 5]);
            end else begin
                mo[int'(gene_idx) - NC] = int'(gene_data[SW-1:0]);
            end
            mst = 0; mpat = 0; mscore = 0;
        end else if (gene_we) begin
            mst = 0; mpat = 0; mscore = 0;
        end else if (mst == 1) begin
            int o, b;
            logic [1:0] t;
            model_eval(mpat, o, b);
            t = tgt_fn(mpat, tsel);
            for (int j = 0; j < N_OUT; j++) if (((o >> j) & 1) == int'(t[j])) mscore++;
            if (mpat == NPAT - 1) mst = 2;
            mpat = (mpat + 1) % NPAT;
        end else if (start) begin
            mst = 1; mpat = 0; mscore = 0;
        end
    end

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            int o, b;
            model_eval((mst == 1) ? mpat : int'(prim_in), o, b);
            chk("R2 prim_out vs model", int'(prim_out), o);
            chk("R5 illegal vs model", int'(illegal), b);
            chk("R9 busy vs model", int'(busy), int'(mst == 1));
            chk("R9 done vs model", int'(done), int'(mst == 2));
            chk("R9 pat_idx vs model", int'(pat_idx), mpat);
            chk("R10 score vs model", int'(score), mscore);
        end
    end

    function automatic logic [GW-1:0] g(int a, int b, int c, int f);
        return GW'(a) | (GW'(b) << SW) | (GW'(c) << (2 * SW)) | (GW'(f) << (3 * SW));
    endfunction

    task automatic wr(input int idx, input logic [GW-1:0] d);
        @(negedge clk); #1;
        gene_we = 1; gene_idx = IW'(idx); gene_data = d;
        @(negedge clk); #1;
        gene_we = 0;
    endtask

    task automatic setp(input int p);
        @(negedge clk); #1;
        prim_in = N_IN'(p);
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk); #1;
        rst_n = 0;
        repeat (2) @(negedge clk);
        #1 rst_n = 1;
    endtask

    task automatic run_sweep(output int cycles);
        @(negedge clk); #1 start = 1;
        @(negedge clk); #1 start = 0;
        cycles = 1;
        while (!done && cycles < 100) begin
            @(negedge clk);
            cycles++;
            #1;
        end
    endtask

    initial begin : wdog
        #(200000 * 4);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        int cyc;
        repeat (2) @(negedge clk);
        #1 rst_n = 1;
        // R12 reset state
        setp(5);
        chk("R12 illegal after reset", int'(illegal), 0);
        chk("R12 score after reset", int'(score), 0);
        chk("R12 busy after reset", int'(busy), 0);
        chk("R12 done after reset", int'(done), 0);
        chk("R12 outputs follow pin 0", int'(prim_out), 3);

        // R3 / R4: every code on cell 0, inputs pins 0,1,2
        wr(NC, g(4, 0, 0, 0));
        for (int code = 0; code < 20; code++) begin
            wr(0, g(0, 1, 2, code));
            for (int p = 0; p < 8; p++) begin
                setp(p);
                if (code < 16)
                    chk($sformatf("R3 code %0d pat %0d", code, p), int'(prim_out[0]),
                        fref(code, p & 1, (p >> 1) & 1, (p >> 2) & 1));
                else
                    chk($sformatf("R4 code %0d pat %0d", code, p), int'(prim_out[0]),
                        fref(code, p & 1, (p >> 1) & 1, (p >> 2) & 1));
            end
        end

        // R6 function code above 19
        wr(0, g(0, 1, 2, 20));
        setp(3);
        chk("R6 code 20 flags", int'(illegal), 1);
        chk("R6 code 20 output", int'(prim_out[0]), 0);
        wr(0, g(0, 0, 0, 1));
        setp(0);
        chk("R6 code 1 clears flag", int'(illegal), 0);
        chk("R6 code 1 output", int'(prim_out[0]), 1);

        // R5 levels-back and feedforward
        wr(12, g(4, 0, 0, 2));
        wr(NC + 1, g(16, 0, 0, 0));
        setp(0);
        chk("R5 col3 reading col0 flags", int'(illegal), 1);
        chk("R5 col3 reading col0 reads 0", int'(prim_out[1]), 0);
        wr(4, g(0, 0, 0, 1));
        wr(12, g(8, 0, 0, 2));
        setp(0);
        chk("R5 col3 reading col1 legal", int'(illegal), 0);
        chk("R5 col3 reading col1 value", int'(prim_out[1]), 1);
        wr(4, g(8, 0, 0, 2));
        setp(0);
        chk("R5 own column flags", int'(illegal), 1);
        chk("R5 own column reads 0", int'(prim_out[1]), 0);
        wr(4, g(12, 0, 0, 2));
        setp(0);
        chk("R5 later column flags", int'(illegal), 1);
        wr(4, g(0, 0, 12, 1));
        setp(0);
        chk("R5 unused third selector still checked", int'(illegal), 1);
        wr(4, g(0, 0, 0, 1));
        setp(0);
        chk("R5 repaired genome legal", int'(illegal), 0);

        // R7 output gene range
        wr(NC, g(25, 0, 0, 0));
        setp(1);
        chk("R7 output pin 25 flags", int'(illegal), 1);
        chk("R7 output pin 25 reads 0", int'(prim_out[0]), 0);
        wr(NC, g(19, 0, 0, 0));
        setp(1);
        chk("R7 output pin 19 legal", int'(illegal), 0);

        // R1 out-of-range index ignored
        wr(31, g(25, 0, 0, 20));
        setp(1);
        chk("R1 index 31 ignored flag", int'(illegal), 0);
        chk("R1 index 31 ignored outputs", int'(prim_out), 2);

        // full adder genome
        do_reset();
        wr(0, g(0, 1, 0, 10));
        wr(1, g(0, 1, 0, 6));
        wr(4, g(4, 2, 0, 10));
        wr(5, g(4, 2, 0, 6));
        wr(8, g(9, 5, 0, 12));
        wr(NC, g(8, 0, 0, 0));
        wr(NC + 1, g(12, 0, 0, 0));
        for (int p = 0; p < 16; p++) begin
            setp(p);
            chk($sformatf("R8 idle full adder pat %0d", p), int'(prim_out), int'(tgt_fn(p, 0)));
        end
        chk("R1 full adder legal", int'(illegal), 0);

        tsel = 0;
        run_sweep(cyc);
        chk("R9 sweep length", cyc, 17);
        chk("R9 done raised", int'(done), 1);
        chk("R10 perfect score", int'(score), 32);
        tsel = 1;
        run_sweep(cyc);
        chk("R9 rerun from DONE", cyc, 17);
        chk("R10 inverted-sum score", int'(score), 16);

        // R11 abort
        tsel = 0;
        @(negedge clk); #1 start = 1;
        @(negedge clk); #1 start = 0;
        repeat (5) @(negedge clk);
        chk("R9 busy mid-run", int'(busy), 1);
        wr(NC, g(8, 0, 0, 0));
        chk("R11 abort busy", int'(busy), 0);
        chk("R11 abort done", int'(done), 0);
        chk("R11 abort score", int'(score), 0);
        repeat (3) @(negedge clk);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule